// File: doc/BRIEF.md
# Multi-Port Test-and-Set Lock

This block is a single-bit ownership lock that several independent register masters share, so that they can take turns at one peripheral. A master tries to take the lock by reading its status register. That read hands back the lock state as it stood before the access, and it sets the lock in the same access. A returned 0 means the reader now owns the lock. A returned 1 means another master already holds it, and the reader should poll again later. The owner gives the lock back by writing 1 to the lock bit. Software performs any timeout by polling.

Each requester has its own simple access port with a read strobe, a write strobe, an address, write data and registered read data. When several ports read the status register in the same cycle while the lock is free, a fixed priority gives the lock to the lowest-numbered port. A registered owner index is provided for debug. The lock output drives the peripheral, or the logic that gates access to it.

Top module: `hw_semaphore`

## Requirements
- R1: After reset the lock is free (`lock_o` = 0), `owner_o` is 0 and every port's `rdata` is 0.
- R2: A read of the status address (parameter `STATUS_ADDR`, default 0x8) while the lock is free returns 0 in bit 0 (`LOCK_BIT`) of that port's `rdata` in the cycle after the strobe, and `lock_o` is 1 from that same cycle on.
- R3: A status read while the lock is held returns 1 in bit 0, and it leaves `lock_o` and `owner_o` unchanged.
- R4: A write with bit 0 of `wdata` = 1 to the status address while the lock is held frees the lock in the following cycle. Any port may do this.
- R5: A status write with bit 0 of `wdata` = 0 does not change the lock, whatever the other data bits hold.
- R6: When several ports read the status address in the same cycle while the lock is free, the lowest-numbered reading port gets 0 and the lock, and every other reading port gets 1.
- R7: `owner_o` gives the index of the port that acquired the lock, from the cycle `lock_o` rises, and it stays stable while the lock is held.
- R8: Reads and writes to any address other than the status address leave the lock unchanged, and such reads return all-zero data.
- R9: In the same cycle, a release takes effect only if the lock was held at the start of that cycle. So a read together with a release of a held lock returns 1 and leaves the lock free, and a read together with a write of 1 to a free lock acquires the lock.
- R10: Each port's `rdata` holds its last read result until that port issues its next read strobe. Status bits other than bit 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | NUM_PORTS | Per-port read strobe, one cycle per access |
| wr_en | input | NUM_PORTS | Per-port write strobe, one cycle per access |
| addr | input | NUM_PORTS*ADDR_W | Per-port register address, port p at bits [p*ADDR_W +: ADDR_W] |
| wdata | input | NUM_PORTS*DATA_W | Per-port write data, port p at bits [p*DATA_W +: DATA_W] |
| rdata | output | NUM_PORTS*DATA_W | Per-port registered read data, valid the cycle after a read strobe |
| lock_o | output | 1 | Lock held |
| owner_o | output | IDX_W | Index of the port holding the lock; meaningful while lock_o is 1 |

## Verification
The assertions assume that strobes, addresses and write data are known and stable across the clock edge at which they are sampled. They also assume that each access lasts exactly one strobe cycle, so a held strobe counts as repeated accesses. The bench drives every input on the falling edge and drops the strobes after a single rising edge. Between accesses it leaves at least one idle cycle, so the results seen at the ports can be traced back to one access. Where a scenario needs several accesses in one cycle, as for same-cycle contention and a release that coincides with a read, the bench presents them on the same falling edge.

// File: rtl/hw_sema_pkg.sv
package hw_sema_pkg;

  // Decoded per-port request toward the shared lock logic
  typedef struct packed {
    logic rd_hit;   // read strobe aimed at the status register
    logic rel;      // write strobe aimed at status with lock bit set
  } port_req_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sema_rst_sync.sv
module sema_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/sema_port_decode.sv
module sema_port_decode
  import hw_sema_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h8,
  parameter int          LOCK_BIT    = 0
) (
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output port_req_t         req
);

  logic hit;
  logic unused_wdata;

  assign hit          = (addr == STATUS_ADDR);
  assign req.rd_hit   = rd_en & hit;
  assign req.rel      = wr_en & hit & wdata[LOCK_BIT];
  // only the lock bit of the write data carries meaning
  assign unused_wdata = ^wdata;

endmodule

// File: rtl/sema_prio_arb.sv
module sema_prio_arb #(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] grant,
  output logic                 grant_any,
  output logic [IDX_W-1:0]     grant_idx
);

  // covered[i] is set when any port below i requests
  logic [NUM_PORTS:0] covered;

  assign covered[0] = 1'b0;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chain
    assign covered[i+1] = covered[i] | req[i];
    assign grant[i]     = req[i] & ~covered[i];
  end

  assign grant_any = covered[NUM_PORTS];

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (grant[i]) grant_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/sema_lock_core.sv
module sema_lock_core #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_any,
  input  logic [IDX_W-1:0] grant_idx,
  input  logic             release_any,
  output logic             lock_q,
  output logic [IDX_W-1:0] owner_q
);

  logic             lock_d;
  logic [IDX_W-1:0] owner_d;
  logic             lock_en;

  // A release only acts on a lock that is already held; a free lock
  // can only be taken by a granted read.
  always_comb begin
    lock_d  = lock_q;
    owner_d = owner_q;
    lock_en = 1'b0;
    if (lock_q) begin
      if (release_any) begin
        lock_d  = 1'b0;
        lock_en = 1'b1;
      end
    end else if (grant_any) begin
      lock_d  = 1'b1;
      owner_d = grant_idx;
      lock_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
    end else if (lock_en) begin
      lock_q  <= lock_d;
      owner_q <= owner_d;
    end
  end

  // R3
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !release_any) |=> lock_q);

  // R4
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && release_any) |=> !lock_q);

  // R7
  owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !release_any) |=> $stable(owner_q));

  // R7
  owner_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && grant_any) |=> (owner_q == $past(grant_idx)));

endmodule

// File: rtl/hw_semaphore.sv
module hw_semaphore
  import hw_sema_pkg::*;
#(
  parameter int          NUM_PORTS   = 4,
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h8,
  parameter int          LOCK_BIT    = 0,
  localparam int         IDX_W       = idx_width(NUM_PORTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          rd_en,
  input  logic [NUM_PORTS-1:0]          wr_en,
  input  logic [NUM_PORTS*ADDR_W-1:0]   addr,
  input  logic [NUM_PORTS*DATA_W-1:0]   wdata,
  output logic [NUM_PORTS*DATA_W-1:0]   rdata,
  output logic                          lock_o,
  output logic [IDX_W-1:0]              owner_o
);

  logic                 rst_sync_n;
  port_req_t            req_s [NUM_PORTS];
  logic [NUM_PORTS-1:0] rd_hit;
  logic [NUM_PORTS-1:0] rel;
  logic [NUM_PORTS-1:0] grant;
  logic                 grant_any;
  logic [IDX_W-1:0]     grant_idx;
  logic                 lock_q;
  logic [IDX_W-1:0]     owner_q;

  sema_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    sema_port_decode #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .STATUS_ADDR (STATUS_ADDR),
      .LOCK_BIT    (LOCK_BIT)
    ) u_dec (
      .rd_en (rd_en[p]),
      .wr_en (wr_en[p]),
      .addr  (addr[p*ADDR_W +: ADDR_W]),
      .wdata (wdata[p*DATA_W +: DATA_W]),
      .req   (req_s[p])
    );

    assign rd_hit[p] = req_s[p].rd_hit;
    assign rel[p]    = req_s[p].rel;

    // Returned value is the state before this access, as seen by this port
    always_comb begin
      rdata_d = '0;
      if (req_s[p].rd_hit) rdata_d[LOCK_BIT] = lock_q | ~grant[p];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)   rdata_q <= '0;
      else if (rd_en[p]) rdata_q <= rdata_d;
    end

    assign rdata[p*DATA_W +: DATA_W] = rdata_q;
  end

  sema_prio_arb #(
    .NUM_PORTS (NUM_PORTS),
    .IDX_W     (IDX_W)
  ) u_arb (
    .req       (rd_hit),
    .grant     (grant),
    .grant_any (grant_any),
    .grant_idx (grant_idx)
  );

  sema_lock_core #(
    .IDX_W (IDX_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .grant_any   (grant_any),
    .grant_idx   (grant_idx),
    .release_any (|rel),
    .lock_q      (lock_q),
    .owner_q     (owner_q)
  );

  assign lock_o  = lock_q;
  assign owner_o = owner_q;

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant));

  // R6
  grant_when_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|rd_hit) |-> (|grant));

  // R2
  acquire_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lock_q && (|rd_hit)) |=> lock_o);

  // R8
  no_touch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(|rd_hit) && !(|rel)) |=> $stable(lock_o));

endmodule

// File: tb/hw_semaphore_tb.sv
`timescale 1ns/1ps
module hw_semaphore_tb;

  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int IW = 2;
  localparam logic [AW-1:0] ST = 4'h8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    rd_en;
  logic [N-1:0]    wr_en;
  logic [N*AW-1:0] addr;
  logic [N*DW-1:0] wdata;
  logic [N*DW-1:0] rdata;
  logic            lock_o;
  logic [IW-1:0]   owner_o;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hw_semaphore #(
    .NUM_PORTS (N), .ADDR_W (AW), .DATA_W (DW), .STATUS_ADDR (ST), .LOCK_BIT (0)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .wr_en (wr_en),
    .addr (addr), .wdata (wdata), .rdata (rdata),
    .lock_o (lock_o), .owner_o (owner_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_of(input int p);
    return rdata[p*DW +: DW];
  endfunction

  // One access cycle with the same address and data on every port
  task automatic access(input logic [N-1:0] rd, input logic [N-1:0] wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = {N{a}}; wdata = {N{d}};
    @(negedge clk);
    rd_en = '0; wr_en = '0;
  endtask

  task automatic t_reset;
    check("R1 lock", lock_o, 0);
    check("R1 owner", owner_o, 0);
    for (int p = 0; p < N; p++) check("R1 rdata", rd_of(p), 0);
  endtask

  task automatic t_acquire_hold;
    access(4'b0100, 4'b0000, ST, 8'h00);
    check("R2 rdata p2", rd_of(2), 8'h00);
    check("R2 lock", lock_o, 1);
    check("R7 owner", owner_o, 2);
    access(4'b0001, 4'b0000, ST, 8'h00);
    check("R3 rdata p0", rd_of(0), 8'h01);
    check("R3 lock", lock_o, 1);
    check("R3 owner", owner_o, 2);
    check("R10 rdata p2 held", rd_of(2), 8'h00);
  endtask

  task automatic t_write_zero;
    access(4'b0000, 4'b0100, ST, 8'h00);
    check("R5 lock after 0x00", lock_o, 1);
    access(4'b0000, 4'b0100, ST, 8'hFE);
    check("R5 lock after 0xFE", lock_o, 1);
    check("R7 owner stable", owner_o, 2);
  endtask

  task automatic t_release;
    access(4'b0000, 4'b0100, ST, 8'h01);
    check("R4 lock freed", lock_o, 0);
  endtask

  task automatic t_other_addr;
    access(4'b0010, 4'b0000, 4'h4, 8'h00);
    check("R8 rdata other addr", rd_of(1), 8'h00);
    check("R8 lock untouched", lock_o, 0);
    access(4'b0010, 4'b0000, ST, 8'h00);
    check("R2 rdata p1", rd_of(1), 8'h00);
    access(4'b0000, 4'b0010, 4'hC, 8'hFF);
    check("R8 lock after other write", lock_o, 1);
    access(4'b1000, 4'b0000, 4'h0, 8'h00);
    check("R8 rdata p3 other", rd_of(3), 8'h00);
    check("R8 owner", owner_o, 1);
    access(4'b0000, 4'b0010, ST, 8'h01);
    check("R4 lock freed p1", lock_o, 0);
  endtask

  task automatic t_contention;
    access(4'b1110, 4'b0000, ST, 8'h00);
    check("R6 p1 wins", rd_of(1), 8'h00);
    check("R6 p2 loses", rd_of(2), 8'h01);
    check("R6 p3 loses", rd_of(3), 8'h01);
    check("R6 owner", owner_o, 1);
    access(4'b0000, 4'b0010, ST, 8'h01);
    access(4'b1111, 4'b0000, ST, 8'h00);
    check("R6 p0 wins", rd_of(0), 8'h00);
    check("R6 p3 loses all", rd_of(3), 8'h01);
    check("R6 owner all", owner_o, 0);
  endtask

  task automatic t_same_cycle;
    // lock held by port 0 here
    access(4'b0010, 4'b1000, ST, 8'h01);
    check("R9 reader sees held", rd_of(1), 8'h01);
    check("R9 lock freed", lock_o, 0);
    access(4'b0100, 4'b1000, ST, 8'h01);
    check("R9 reader acquires", rd_of(2), 8'h00);
    check("R9 lock held", lock_o, 1);
    check("R9 owner", owner_o, 2);
    access(4'b0000, 4'b0100, ST, 8'h01);
    check("R4 final release", lock_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; rd_en = '0; wr_en = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_acquire_hold();
    t_write_zero();
    t_release();
    t_other_addr();
    t_contention();
    t_same_cycle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule